// File: doc/BRIEF.md
# Multiplexed Burst Bus Master

This block drives a shared 32-bit address/data bus on behalf of one internal requester. Each request names a direction, a start address and a beat count of one to four words. The block runs the bus through four states: one address state, a data phase paced by a ready input, and one recovery state, after which the bus goes idle or straight into the next transaction. Writes place their words on the shared lines. Reads return each word on a separate port with a one-cycle valid strobe.

A read of four words whose start address sits two bytes past a word boundary is split into two bus accesses. The first is a four-beat access that enables only the upper half of each word. The second is a one-beat access at the next aligned block that enables only the lower half. A read can be flagged as locked. The lock output then rises with that read's address state and drops with the address state of the next write, which gives an indivisible read-modify-write pair. An error input is sampled during each recovery state, and the requester gets a one-cycle done pulse with an error flag.

Top module: `mbus_master`

## Requirements
- R1: An access starts with exactly one address state in which `ale_o` and `ads_o` are high, `lad_oe_o` is high, `lad_o` carries the word-aligned access address and `be_o` carries the access byte enables, which stay constant through the data phase.
- R2: The data phase follows the address state directly with `den_o` high. A cycle with `ready_i` low is a wait state and a cycle with `ready_i` high completes one beat. Exactly one recovery state (`den_o` low, `lad_oe_o` low) follows the last beat.
- R3: A transaction that is not split carries `req_len_i`+1 beats under a single address. On a write, beat b drives bits [32b+31:32b] of `req_wdata_i` on `lad_o`.
- R4: From the accepting clock edge to the cycle in which `done_o` is high, the number of cycles is the sum over all accesses of (2 + beats + wait states) plus 1.
- R5: A read with `req_len_i`=3 and `req_addr_i[1:0]`=2 is issued as two accesses. The first is at the aligned address with 4 beats and `be_o`=4'b1100. The second is at the aligned address plus 16 with 1 beat and `be_o`=4'b0011. Five read words are returned.
- R6: In every other case `req_addr_i[1:0]` is ignored: the address is aligned down and `be_o`=4'b1111.
- R7: `lock_o` is high in the address state of an accepted read that has `req_lock_i`=1. It is low from the address state of the next accepted write. A read without the lock flag leaves it unchanged.
- R8: One cycle after each read beat, `rvalid_o` pulses with `rdata_o` equal to the `lad_i` value of that beat, in beat order.
- R9: `bad_i` is sampled only in recovery states. `err_o` is the OR of those samples over all accesses of the transaction, and `bad_i` in any other cycle has no effect.
- R10: `wr_o` and `dtr_o` are high for a write and low for a read from the address state through recovery, and low when idle. `den_o` is high only in wait and data states. `lad_oe_o` is low during a read data phase and in recovery.
- R11: `req_ready_o` is high only when idle or in the recovery state of a transaction's final access, so a request held pending is accepted on leaving recovery with no idle cycle. `done_o` is a one-cycle pulse in the cycle after the final recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_lock_i | input | 1 | Read starts a locked read-modify-write |
| req_addr_i | input | 32 | Byte start address |
| req_len_i | input | 2 | Beats minus one |
| req_wdata_i | input | 128 | Write words, beat b at bits [32b+31:32b] |
| rdata_o | output | 32 | Returned read word |
| rvalid_o | output | 1 | rdata_o valid this cycle |
| done_o | output | 1 | Transaction complete pulse |
| err_o | output | 1 | Bad access seen, valid with done_o |
| lad_o | output | 32 | Shared lines, outgoing address or data |
| lad_oe_o | output | 1 | Drive enable for lad_o |
| lad_i | input | 32 | Shared lines, incoming data |
| ale_o | output | 1 | Address latch enable |
| ads_o | output | 1 | Address state strobe |
| wr_o | output | 1 | Write/read direction |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| den_o | output | 1 | Data transceiver enable |
| be_o | output | 4 | Byte enables |
| lock_o | output | 1 | Bus lock |
| ready_i | input | 1 | Slave ready, completes a beat |
| bad_i | input | 1 | Bad access, sampled in recovery |

## Verification
The assertions check the state-order rules on every cycle: an address state lasts one cycle and is followed by the data phase, the master never drives the lines during a read data phase or in recovery, no request is accepted mid-transaction, the direction holds through the data phase, and the lock is low on every write's address state. Only the bench's scenarios can show the values. That covers split addresses and byte enables, beat counts, write words, the order of returned read data, the latency under a given ready pattern, the error OR across split accesses, and that error noise outside recovery is ignored.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_RECOV = 2'd3
  } bus_st_e;
endpackage

// File: rtl/mbus_plan.sv
// Turns a request into one or two bus accesses.
module mbus_plan #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4
) (
  input  logic                         req_write_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [$clog2(MAX_BEATS)-1:0] req_len_i,
  output logic [ADDR_W-1:0]            a0_addr_o,
  output logic [DATA_W/8-1:0]          a0_be_o,
  output logic [$clog2(MAX_BEATS)-1:0] a0_last_o,
  output logic                         split_o,
  output logic [ADDR_W-1:0]            a1_addr_o,
  output logic [DATA_W/8-1:0]          a1_be_o
);
  localparam int BE_W   = DATA_W / 8;
  localparam int OFF_W  = $clog2(BE_W);
  localparam int HALF   = BE_W / 2;
  localparam int LEN_W  = $clog2(MAX_BEATS);
  localparam int STRIDE = MAX_BEATS * BE_W;

  logic [BE_W-1:0]   hi_mask;
  logic [ADDR_W-1:0] aligned;

  for (genvar g = 0; g < BE_W; g++) begin : g_mask
    assign hi_mask[g] = (g >= HALF) ? 1'b1 : 1'b0;
  end

  assign aligned   = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign split_o   = !req_write_i && (req_len_i == LEN_W'(MAX_BEATS - 1)) &&
                     (req_addr_i[OFF_W-1:0] == OFF_W'(HALF));
  assign a0_addr_o = aligned;
  assign a0_be_o   = split_o ? hi_mask : {BE_W{1'b1}};
  assign a0_last_o = req_len_i;
  assign a1_addr_o = aligned + ADDR_W'(STRIDE);
  assign a1_be_o   = ~hi_mask;
endmodule

// File: rtl/mbus_seq.sv
// Bus state sequencer: address, data/wait, recovery.
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic                         req_write_i,
  input  logic                         req_lock_i,
  input  logic [MAX_BEATS*DATA_W-1:0]  req_wdata_i,
  input  logic [ADDR_W-1:0]            a0_addr_i,
  input  logic [DATA_W/8-1:0]          a0_be_i,
  input  logic [$clog2(MAX_BEATS)-1:0] a0_last_i,
  input  logic                         split_i,
  input  logic [ADDR_W-1:0]            a1_addr_i,
  input  logic [DATA_W/8-1:0]          a1_be_i,
  input  logic                         ready_i,
  input  logic                         bad_i,
  output logic [DATA_W-1:0]            lad_o,
  output logic                         lad_oe_o,
  output logic                         ale_o,
  output logic                         ads_o,
  output logic                         wr_o,
  output logic                         dtr_o,
  output logic                         den_o,
  output logic [DATA_W/8-1:0]          be_o,
  output logic                         lock_o,
  output logic                         rd_take_o,
  output logic                         done_o,
  output logic                         err_o
);
  localparam int BE_W  = DATA_W / 8;
  localparam int LEN_W = $clog2(MAX_BEATS);

  bus_st_e                     st_q;
  logic [LEN_W-1:0]            beat_q, last_q;
  logic                        split_q, write_q, lock_q, err_acc_q, done_q, err_q;
  logic [ADDR_W-1:0]           cur_addr_q, a1_addr_q;
  logic [BE_W-1:0]             cur_be_q, a1_be_q;
  logic [MAX_BEATS*DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0]           wbeat;
  logic                        accept, last_beat;

  assign req_ready_o = (st_q == ST_IDLE) || ((st_q == ST_RECOV) && !split_q);
  assign accept      = req_valid_i && req_ready_o;
  assign last_beat   = (beat_q == last_q);
  assign wbeat       = wdata_q[32'(beat_q)*DATA_W +: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      beat_q     <= '0;
      last_q     <= '0;
      split_q    <= 1'b0;
      write_q    <= 1'b0;
      lock_q     <= 1'b0;
      err_acc_q  <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      cur_addr_q <= '0;
      a1_addr_q  <= '0;
      cur_be_q   <= '0;
      a1_be_q    <= '0;
      wdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) st_q <= ST_ADDR;
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: begin
          if (ready_i) begin
            if (last_beat) st_q <= ST_RECOV;
            else           beat_q <= beat_q + LEN_W'(1);
          end
        end
        ST_RECOV: begin
          if (split_q) begin
            st_q       <= ST_ADDR;
            cur_addr_q <= a1_addr_q;
            cur_be_q   <= a1_be_q;
            last_q     <= '0;
            beat_q     <= '0;
            split_q    <= 1'b0;
            err_acc_q  <= err_acc_q | bad_i;
          end else begin
            done_q <= 1'b1;
            err_q  <= err_acc_q | bad_i;
            st_q   <= accept ? ST_ADDR : ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (accept) begin
        cur_addr_q <= a0_addr_i;
        cur_be_q   <= a0_be_i;
        last_q     <= a0_last_i;
        beat_q     <= '0;
        split_q    <= split_i;
        a1_addr_q  <= a1_addr_i;
        a1_be_q    <= a1_be_i;
        write_q    <= req_write_i;
        wdata_q    <= req_wdata_i;
        err_acc_q  <= 1'b0;
        if (req_write_i)     lock_q <= 1'b0;
        else if (req_lock_i) lock_q <= 1'b1;
      end
    end
  end

  always_comb begin
    lad_o = '0;
    if (st_q == ST_ADDR)                 lad_o = DATA_W'(cur_addr_q);
    else if (st_q == ST_DATA && write_q) lad_o = wbeat;
  end

  assign lad_oe_o  = (st_q == ST_ADDR) || ((st_q == ST_DATA) && write_q);
  assign ale_o     = (st_q == ST_ADDR);
  assign ads_o     = (st_q == ST_ADDR);
  assign wr_o      = write_q && (st_q != ST_IDLE);
  assign dtr_o     = write_q && (st_q != ST_IDLE);
  assign den_o     = (st_q == ST_DATA);
  assign be_o      = (st_q != ST_IDLE) ? cur_be_q : '0;
  assign lock_o    = lock_q;
  assign rd_take_o = (st_q == ST_DATA) && ready_i && !write_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/mbus_rcap.sv
// Registers each completed read beat.
module mbus_rcap #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [DATA_W-1:0] lad_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= take_i;
      if (take_i) rdata_o <= lad_i;
    end
  end
endmodule

// File: rtl/mbus_master.sv
module mbus_master #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic                         req_write_i,
  input  logic                         req_lock_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [$clog2(MAX_BEATS)-1:0] req_len_i,
  input  logic [MAX_BEATS*DATA_W-1:0]  req_wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         rvalid_o,
  output logic                         done_o,
  output logic                         err_o,
  output logic [DATA_W-1:0]            lad_o,
  output logic                         lad_oe_o,
  input  logic [DATA_W-1:0]            lad_i,
  output logic                         ale_o,
  output logic                         ads_o,
  output logic                         wr_o,
  output logic                         dtr_o,
  output logic                         den_o,
  output logic [DATA_W/8-1:0]          be_o,
  output logic                         lock_o,
  input  logic                         ready_i,
  input  logic                         bad_i
);
  localparam int BE_W  = DATA_W / 8;
  localparam int LEN_W = $clog2(MAX_BEATS);

  logic [ADDR_W-1:0] a0_addr, a1_addr;
  logic [BE_W-1:0]   a0_be, a1_be;
  logic [LEN_W-1:0]  a0_last;
  logic              split, rd_take;

  mbus_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)) plan_i (
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .a0_addr_o(a0_addr), .a0_be_o(a0_be), .a0_last_o(a0_last), .split_o(split),
    .a1_addr_o(a1_addr), .a1_be_o(a1_be)
  );

  mbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_lock_i(req_lock_i), .req_wdata_i(req_wdata_i),
    .a0_addr_i(a0_addr), .a0_be_i(a0_be), .a0_last_i(a0_last), .split_i(split),
    .a1_addr_i(a1_addr), .a1_be_i(a1_be),
    .ready_i(ready_i), .bad_i(bad_i),
    .lad_o(lad_o), .lad_oe_o(lad_oe_o), .ale_o(ale_o), .ads_o(ads_o),
    .wr_o(wr_o), .dtr_o(dtr_o), .den_o(den_o), .be_o(be_o), .lock_o(lock_o),
    .rd_take_o(rd_take), .done_o(done_o), .err_o(err_o)
  );

  mbus_rcap #(.DATA_W(DATA_W)) rcap_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(rd_take), .lad_i(lad_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/mbus_master_chk.sv
module mbus_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic ads_o,
  input logic den_o,
  input logic wr_o,
  input logic lad_oe_o,
  input logic lock_o,
  input logic req_ready_o,
  input logic done_o
);
  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R1
  AST_ADDR_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ads_o && lad_oe_o)); // R1
  AST_ADDR_THEN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> den_o); // R2
  AST_RECOV_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(den_o) |-> (!lad_oe_o && !ale_o)); // R2
  AST_READ_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_o && !wr_o) |-> !lad_oe_o); // R10
  AST_DEN_OFF_IN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !den_o); // R10
  AST_DIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den_o |-> $stable(wr_o)); // R10
  AST_WRITE_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && wr_o) |-> !lock_o); // R7
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o || den_o) |-> !req_ready_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

bind mbus_master mbus_master_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ale_o(ale_o), .ads_o(ads_o), .den_o(den_o),
  .wr_o(wr_o), .lad_oe_o(lad_oe_o), .lock_o(lock_o), .req_ready_o(req_ready_o),
  .done_o(done_o)
);

// File: tb/mbus_master_tb_top.sv
`timescale 1ns/1ps
module mbus_master_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_len = '0;
  logic [127:0] req_wdata = '0;
  logic [31:0]  rdata, lad_o, lad_i = '0;
  logic         req_ready, rvalid, done, err, lad_oe, ale, ads, wr, dtr, den, lock;
  logic [3:0]   be;
  logic         ready_i = 1'b0, bad_i = 1'b0;

  always #2 clk = ~clk;

  mbus_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_lock_i(req_lock), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_wdata_i(req_wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .done_o(done), .err_o(err), .lad_o(lad_o), .lad_oe_o(lad_oe), .lad_i(lad_i),
    .ale_o(ale), .ads_o(ads), .wr_o(wr), .dtr_o(dtr), .den_o(den), .be_o(be),
    .lock_o(lock), .ready_i(ready_i), .bad_i(bad_i)
  );

  // Knobs written by the stimulus process, read by the slave model
  int   w_first = 0, w_next = 0;
  logic bad_noise = 1'b0;
  logic bad_at [0:511];

  // Slave model logs
  logic [31:0] acc_addr [0:511];
  logic [3:0]  acc_be   [0:511];
  logic        acc_lock [0:511];
  logic        acc_wr   [0:511];
  int          acc_beats[0:511];
  logic [31:0] wcap [0:1023];
  logic [31:0] rcap [0:1023];
  int acc_n = 0, wcap_n = 0, rcap_n = 0, proto_err = 0;
  int s_beat = 0, s_wcnt = 0;
  logic s_prev_ready = 1'b0;

  function automatic logic [31:0] rd_fn(input logic [31:0] a, input int b);
    return (a * 32'h9E37_79B9) ^ (32'(b) << 8) ^ 32'h1357_2468;
  endfunction

  always @(negedge clk) begin
    if (rvalid) begin
      rcap[rcap_n % 1024] = rdata;
      rcap_n++;
    end
    ready_i = 1'b0;
    bad_i   = bad_noise;
    lad_i   = 32'h0BAD_F00D;
    if (ale) begin
      acc_addr[acc_n % 512] = lad_o;
      acc_be[acc_n % 512]   = be;
      acc_lock[acc_n % 512] = lock;
      acc_wr[acc_n % 512]   = wr;
      acc_beats[acc_n % 512] = 0;
      acc_n++;
      s_beat = 0;
      s_wcnt = 0;
    end else if (den) begin
      if (acc_n == 0) proto_err++;
      else begin
        if (be != acc_be[(acc_n-1) % 512]) proto_err++;
        if (wr != acc_wr[(acc_n-1) % 512] || dtr != wr) proto_err++;
        if (!wr && lad_oe) proto_err++;
        if (s_wcnt >= (s_beat == 0 ? w_first : w_next)) begin
          ready_i = 1'b1;
          if (wr) begin
            wcap[wcap_n % 1024] = lad_o;
            wcap_n++;
          end else lad_i = rd_fn(acc_addr[(acc_n-1) % 512], s_beat);
          s_beat++;
          acc_beats[(acc_n-1) % 512] = s_beat;
          s_wcnt = 0;
        end else s_wcnt++;
      end
    end else if (s_prev_ready) begin
      if (lad_oe) proto_err++;
      if (acc_n > 0 && (wr != acc_wr[(acc_n-1) % 512] || dtr != wr)) proto_err++;
      bad_i = (acc_n > 0) ? bad_at[(acc_n-1) % 512] : 1'b0;
    end else begin
      if (wr || dtr || lad_oe) proto_err++;
    end
    s_prev_ready = ready_i;
  end

  int checks = 0, errors = 0;
  logic lock_exp = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr_i, input logic lk_i, input logic [31:0] addr,
                         input logic [1:0] len, input logic [127:0] wd,
                         input int a0, input int a1, input logic [1:0] bm,
                         input logic noise);
    int n_acc, exp_lat, lat, base_a, base_w, base_r, base_p, k2;
    logic [31:0] ea[2];
    logic [3:0]  eb[2];
    int          en[2];
    logic        exp_err, got_err, seen;
    logic [31:0] al;
    al = {addr[31:2], 2'b00};
    if (!wr_i && len == 2'd3 && addr[1:0] == 2'd2) begin
      n_acc = 2; ea[0] = al; eb[0] = 4'b1100; en[0] = 4;
      ea[1] = al + 32'd16; eb[1] = 4'b0011; en[1] = 1;
    end else begin
      n_acc = 1; ea[0] = al; eb[0] = 4'b1111; en[0] = int'(len) + 1;
      ea[1] = '0; eb[1] = '0; en[1] = 0;
    end
    if (wr_i) lock_exp = 1'b0;
    else if (lk_i) lock_exp = 1'b1;
    exp_lat = 1;
    for (int k = 0; k < n_acc; k++) exp_lat += 2 + en[k] + a0 + (en[k] - 1) * a1;
    exp_err = bm[0] | ((n_acc == 2) & bm[1]);
    @(negedge clk);
    base_a = acc_n; base_w = wcap_n; base_r = rcap_n; base_p = proto_err;
    bad_at[base_a % 512] = bm[0];
    bad_at[(base_a + 1) % 512] = bm[1];
    w_first = a0; w_next = a1; bad_noise = noise;
    req_write = wr_i; req_lock = lk_i; req_addr = addr; req_len = len; req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 0; seen = 1'b0; got_err = 1'b0;
    while (!seen && lat < 500) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (done) begin seen = 1'b1; got_err = err; end
    end
    bad_noise = 1'b0;
    chk(seen && lat == exp_lat, "R4 latency", 128'(lat), 128'(exp_lat));
    chk(acc_n - base_a == n_acc, "R5 access count", 128'(acc_n - base_a), 128'(n_acc));
    for (int k = 0; k < n_acc; k++) begin
      k2 = (base_a + k) % 512;
      chk(acc_addr[k2] == ea[k], "R1 address", 128'(acc_addr[k2]), 128'(ea[k]));
      chk(acc_be[k2] == eb[k], (n_acc == 2) ? "R5 byte enables" : "R6 byte enables",
          128'(acc_be[k2]), 128'(eb[k]));
      chk(acc_beats[k2] == en[k], "R3 beats", 128'(acc_beats[k2]), 128'(en[k]));
      chk(acc_lock[k2] == lock_exp, "R7 lock", 128'(acc_lock[k2]), 128'(lock_exp));
      chk(acc_wr[k2] == wr_i, "R10 direction", 128'(acc_wr[k2]), 128'(wr_i));
    end
    if (wr_i) begin
      for (int b = 0; b < en[0]; b++)
        chk(wcap[(base_w + b) % 1024] == wd[b*32 +: 32], "R3 write word",
            128'(wcap[(base_w + b) % 1024]), 128'(wd[b*32 +: 32]));
    end else begin
      int idx;
      idx = base_r;
      chk(rcap_n - base_r == en[0] + en[1], "R8 read count",
          128'(rcap_n - base_r), 128'(en[0] + en[1]));
      for (int k = 0; k < n_acc; k++)
        for (int b = 0; b < en[k]; b++) begin
          chk(rcap[idx % 1024] == rd_fn(ea[k], b), "R8 read word",
              128'(rcap[idx % 1024]), 128'(rd_fn(ea[k], b)));
          idx++;
        end
    end
    chk(got_err == exp_err, "R9 error flag", 128'(got_err), 128'(exp_err));
    chk(proto_err == base_p, "R10 bus protocol", 128'(proto_err - base_p), 128'(0));
    @(negedge clk);
    chk(!done, "R11 done pulse", 128'(done), 128'(0));
  endtask

  task automatic back_to_back();
    int lat, done_at, base_r;
    logic ale_at_done, rdy_busy;
    @(negedge clk);
    base_r = rcap_n;
    bad_at[acc_n % 512] = 1'b0;
    bad_at[(acc_n + 1) % 512] = 1'b0;
    w_first = 0; w_next = 0;
    req_write = 1'b0; req_lock = 1'b0; req_addr = 32'h0000_4000; req_len = 2'd0;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'h0000_5000;  // second request held pending
    rdy_busy = req_ready;
    lat = 1; done_at = 0; ale_at_done = 1'b0;
    while (done_at == 0 && lat < 50) begin
      @(negedge clk);
      lat++;
      if (ale && lat == 2) rdy_busy = 1'b1;
      if (done) begin done_at = lat; ale_at_done = ale; req_valid = 1'b0; end
    end
    chk(done_at == 4, "R11 first done cycle", 128'(done_at), 128'(4));
    chk(ale_at_done, "R11 accepted on leaving recovery", 128'(ale_at_done), 128'(1));
    chk(!rdy_busy, "R11 not ready while busy", 128'(rdy_busy), 128'(0));
    done_at = 0;
    while (done_at == 0 && lat < 50) begin
      @(negedge clk);
      lat++;
      if (done) done_at = lat;
    end
    chk(done_at == 7, "R11 second done cycle", 128'(done_at), 128'(7));
    chk(rcap_n - base_r == 2 && rcap[(base_r + 1) % 1024] == rd_fn(32'h0000_5000, 0),
        "R8 back-to-back data", 128'(rcap[(base_r + 1) % 1024]), 128'(rd_fn(32'h0000_5000, 0)));
  endtask

  task automatic run_all();
    logic wr_r, lk_r;
    logic [31:0] ad_r;
    logic [1:0] ln_r, bm_r;
    // reset state
    @(negedge clk);
    chk(!ale && !den && !lad_oe && !wr && !dtr && !lock && !done && !rvalid,
        "R10 reset outputs", {ale, den, lad_oe, wr, dtr, lock, done, rvalid}, 128'(0));
    chk(req_ready, "R11 ready at reset", 128'(req_ready), 128'(1));
    // directed corner cases
    run_txn(1'b0, 1'b0, 32'h0000_1000, 2'd0, '0, 0, 0, 2'b00, 1'b0);
    run_txn(1'b1, 1'b0, 32'h0000_1004, 2'd0, 128'hCAFE_0001, 2, 0, 2'b00, 1'b0);
    run_txn(1'b0, 1'b0, 32'h0000_2000, 2'd3, '0, 2, 1, 2'b00, 1'b0);
    run_txn(1'b1, 1'b0, 32'h0000_3000, 2'd3,
            128'h4444_4444_3333_3333_2222_2222_1111_1111, 0, 0, 2'b00, 1'b0);
    run_txn(1'b0, 1'b0, 32'h0000_6002, 2'd3, '0, 1, 0, 2'b01, 1'b0);  // R5 split, error on first part
    run_txn(1'b0, 1'b0, 32'h0000_7003, 2'd1, '0, 0, 1, 2'b00, 1'b0);  // R6 odd offset
    run_txn(1'b1, 1'b0, 32'h0000_7102, 2'd3, 128'h1, 0, 0, 2'b00, 1'b0); // R6 write offset 2
    run_txn(1'b0, 1'b1, 32'h0000_8000, 2'd0, '0, 0, 0, 2'b00, 1'b0);  // R7 locked read
    run_txn(1'b0, 1'b0, 32'h0000_8010, 2'd0, '0, 0, 0, 2'b00, 1'b0);  // R7 lock kept
    run_txn(1'b1, 1'b0, 32'h0000_8000, 2'd0, 128'h77, 1, 0, 2'b00, 1'b0); // R7 release
    run_txn(1'b0, 1'b0, 32'h0000_9000, 2'd2, '0, 1, 2, 2'b00, 1'b1);  // R9 noise ignored
    run_txn(1'b1, 1'b0, 32'h0000_9100, 2'd1, 128'h55, 0, 0, 2'b01, 1'b0); // R9 error
    back_to_back();
    // constrained random
    for (int i = 0; i < 60; i++) begin
      wr_r = 1'($urandom % 2);
      ln_r = 2'($urandom % 4);
      ad_r = $urandom & 32'h000F_FFFF;
      if (!wr_r && ($urandom % 3) == 0) begin ln_r = 2'd3; ad_r[1:0] = 2'd2; end
      lk_r = !wr_r && (($urandom % 4) == 0);
      bm_r = {1'(($urandom % 6) == 0), 1'(($urandom % 6) == 0)};
      run_txn(wr_r, lk_r, ad_r, ln_r, {$urandom, $urandom, $urandom, $urandom},
              int'($urandom % 3), int'($urandom % 3), bm_r, 1'(($urandom % 5) == 0));
    end
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    for (int i = 0; i < 512; i++) bad_at[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule